// File: doc/BRIEF.md
# Bit-Manipulation-Safe Port and Interrupt Flag Registers

This block is an 8-bit peripheral register file with two halves. The port half holds an output latch and a direction register and observes a set of external pin levels. The flag half holds interrupt request flags, which hardware event inputs set and software clears by writing zero, and a matching set of enable bits. An AND-OR of flags and enables forms a single interrupt request.

The bus is a plain strobe interface: a 2-bit register select, a read strobe, a write strobe, write data and a qualifier that is high during the read phase of a bit set or bit clear instruction. Such an instruction reads the whole byte, changes one bit and writes the whole byte back. On that qualified read the block returns values chosen so that the write-back cannot disturb the other bits. The port returns its latch instead of the pins. Every implemented flag reads as 1, so the write-back of those bits is a no-op. Read data is combinational and valid in the same cycle as the read strobe. Writes take effect at the next clock edge.

Top module: `rmw_port_irq_regs`

## Requirements
- R1: After synchronous reset the latch, direction, flag and enable registers are all zero, so `pin_oe_o` is 0, `pin_out_o` is 0 and `irq_o` is 0.
- R2: A write with select 0 loads the port latch at the next edge. `pin_out_o` always shows the latch and `pin_oe_o` shows the direction register (1 = drive the pin, 0 = leave it undriven).
- R3: A read of select 0 with the qualifier low returns `pin_i`.
- R4: A read of select 0 with the qualifier high returns the port latch, whatever the direction bits and pin levels.
- R5: A read of select 2 with the qualifier low returns the pending flags in bits [NFLAG-1:0] and 0 in the bits above.
- R6: A read of select 2 with the qualifier high returns 1 in every bit [NFLAG-1:0] and 0 in the bits above.
- R7: A write with select 2 clears each flag whose data bit is 0 and leaves each flag whose data bit is 1 unchanged. A write never sets a flag.
- R8: An event input high in a cycle sets its flag at the next edge, and this takes priority over a clearing write in the same cycle.
- R9: `irq_o` is high exactly when some flag and its enable bit are both 1.
- R10: Select 1 (direction) and select 3 (enables, bits [NFLAG-1:0] only) are written whole and read back unchanged whatever the qualifier.
- R11: `rd_data_o` is 0 in any cycle where `rd_i` is low. The qualifier has no effect on writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| addr_i | input | 2 | Register select: 0 port data, 1 direction, 2 flags, 3 enables |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| rmw_i | input | 1 | High during the read phase of a bit-manipulation instruction |
| wdata_i | input | 8 | Write data |
| rd_data_o | output | 8 | Read data, valid in the strobe cycle |
| pin_i | input | 8 | Sampled pin levels |
| pin_out_o | output | 8 | Level to drive on each pin |
| pin_oe_o | output | 8 | Per-pin drive enable |
| evt_i | input | NFLAG | Hardware event per flag |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The assertions take for granted that the select, strobes, qualifier and write data hold defined values at each edge, and that `pin_i` is steady across a read cycle. They do not assume that reads and writes are exclusive, since a same-cycle read returns the state before the write. The bench drives every input to a defined value half a cycle before each edge. It holds the pins constant within a cycle and mixes simultaneous strobes, qualified writes and clear-versus-event collisions into both the directed and the random phases.

// File: rtl/rmw_regs_pkg.sv
`timescale 1ns/1ps
package rmw_regs_pkg;

    localparam int DATA_W = 8;
    localparam int SEL_W  = 2;

    typedef enum logic [SEL_W-1:0] {
        SEL_DATA = 2'd0,
        SEL_DIR  = 2'd1,
        SEL_FLAG = 2'd2,
        SEL_EN   = 2'd3
    } reg_sel_e;

    typedef logic [DATA_W-1:0] byte_t;

    typedef struct packed {
        logic     rd;
        logic     wr;
        logic     rmw;
        reg_sel_e sel;
        byte_t    wdata;
    } bus_req_t;

    // Mask with the low n bits set, limited to the data width.
    function automatic byte_t low_mask(input int n);
        byte_t m;
        m = '0;
        for (int i = 0; i < DATA_W; i++) begin
            if (i < n) m[i] = 1'b1;
        end
        return m;
    endfunction

    // Value seen on a flag read: pending bits, or all implemented bits on the qualified read.
    function automatic byte_t flag_view(input byte_t flags, input logic rmw, input byte_t impl);
        return rmw ? impl : (flags & impl);
    endfunction

endpackage

// File: rtl/rmw_port_bank.sv
`timescale 1ns/1ps
module rmw_port_bank
    import rmw_regs_pkg::*;
(
    input  logic     clk_i,
    input  logic     rst_i,
    input  bus_req_t req_i,
    input  byte_t    pin_i,
    output byte_t    latch_o,
    output byte_t    dir_o,
    output byte_t    rd_val_o
);

    byte_t latch_q;
    byte_t dir_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            latch_q <= '0;
            dir_q   <= '0;
        end else if (req_i.wr) begin
            if (req_i.sel == SEL_DATA) latch_q <= req_i.wdata;
            if (req_i.sel == SEL_DIR)  dir_q   <= req_i.wdata;
        end
    end

    always_comb begin
        rd_val_o = '0;
        if (req_i.rd) begin
            unique case (req_i.sel)
                SEL_DATA: rd_val_o = req_i.rmw ? latch_q : pin_i;
                SEL_DIR:  rd_val_o = dir_q;
                default:  rd_val_o = '0;
            endcase
        end
    end

    assign latch_o = latch_q;
    assign dir_o   = dir_q;

    a_r2_latch_load: assert property (@(posedge clk_i) disable iff (rst_i)
        (req_i.wr && req_i.sel == SEL_DATA) |=> (latch_o == $past(req_i.wdata)));

    a_r2_latch_hold: assert property (@(posedge clk_i) disable iff (rst_i)
        !(req_i.wr && req_i.sel == SEL_DATA) |=> $stable(latch_o));

    a_r10_dir_hold: assert property (@(posedge clk_i) disable iff (rst_i)
        !(req_i.wr && req_i.sel == SEL_DIR) |=> $stable(dir_o));

endmodule

// File: rtl/rmw_flag_bank.sv
`timescale 1ns/1ps
module rmw_flag_bank
    import rmw_regs_pkg::*;
#(
    parameter int NFLAG = 6
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  bus_req_t         req_i,
    input  logic [NFLAG-1:0] evt_i,
    output byte_t            flags_o,
    output byte_t            rd_val_o,
    output logic             irq_o
);

    localparam byte_t IMPL = low_mask(NFLAG);

    byte_t flag_q;
    byte_t en_q;
    byte_t evt_ext;
    byte_t flag_d;

    always_comb begin
        evt_ext = '0;
        for (int i = 0; i < NFLAG; i++) evt_ext[i] = evt_i[i];
    end

    // Events are merged after the clearing write so a same-cycle event survives.
    always_comb begin
        flag_d = flag_q;
        if (req_i.wr && req_i.sel == SEL_FLAG) flag_d = flag_d & req_i.wdata;
        flag_d = (flag_d | evt_ext) & IMPL;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            flag_q <= '0;
            en_q   <= '0;
        end else begin
            flag_q <= flag_d;
            if (req_i.wr && req_i.sel == SEL_EN) en_q <= req_i.wdata & IMPL;
        end
    end

    always_comb begin
        rd_val_o = '0;
        if (req_i.rd) begin
            unique case (req_i.sel)
                SEL_FLAG: rd_val_o = flag_view(flag_q, req_i.rmw, IMPL);
                SEL_EN:   rd_val_o = en_q;
                default:  rd_val_o = '0;
            endcase
        end
    end

    assign flags_o = flag_q;
    assign irq_o   = |(flag_q & en_q);

    a_r8_event_sets: assert property (@(posedge clk_i) disable iff (rst_i)
        1'b1 |=> ((flags_o[NFLAG-1:0] & $past(evt_i)) == $past(evt_i)));

    a_r7_no_spurious_set: assert property (@(posedge clk_i) disable iff (rst_i)
        1'b1 |=> ((flags_o[NFLAG-1:0] & ~$past(flags_o[NFLAG-1:0]) & ~$past(evt_i)) == '0));

    a_r7_zero_clears: assert property (@(posedge clk_i) disable iff (rst_i)
        (req_i.wr && req_i.sel == SEL_FLAG) |=>
        ((flags_o[NFLAG-1:0] & ~$past(req_i.wdata[NFLAG-1:0]) & ~$past(evt_i)) == '0));

    a_r5_unused_zero: assert property (@(posedge clk_i) disable iff (rst_i)
        (flags_o & ~IMPL) == '0);

endmodule

// File: rtl/rmw_port_irq_regs.sv
`timescale 1ns/1ps
module rmw_port_irq_regs
    import rmw_regs_pkg::*;
#(
    parameter int NFLAG = 6
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [1:0]       addr_i,
    input  logic             rd_i,
    input  logic             wr_i,
    input  logic             rmw_i,
    input  logic [7:0]       wdata_i,
    output logic [7:0]       rd_data_o,
    input  logic [7:0]       pin_i,
    output logic [7:0]       pin_out_o,
    output logic [7:0]       pin_oe_o,
    input  logic [NFLAG-1:0] evt_i,
    output logic             irq_o
);

    localparam byte_t IMPL = low_mask(NFLAG);

    bus_req_t req;
    byte_t    port_rd;
    byte_t    flag_rd;
    byte_t    latch;
    byte_t    dir;
    byte_t    flags;

    always_comb begin
        req.rd    = rd_i;
        req.wr    = wr_i;
        req.rmw   = rmw_i;
        req.sel   = reg_sel_e'(addr_i);
        req.wdata = wdata_i;
    end

    rmw_port_bank u_port (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .req_i    (req),
        .pin_i    (pin_i),
        .latch_o  (latch),
        .dir_o    (dir),
        .rd_val_o (port_rd)
    );

    rmw_flag_bank #(.NFLAG(NFLAG)) u_flag (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .req_i    (req),
        .evt_i    (evt_i),
        .flags_o  (flags),
        .rd_val_o (flag_rd),
        .irq_o    (irq_o)
    );

    // Each bank returns zero outside its own selects, so an OR is the read mux.
    assign rd_data_o = port_rd | flag_rd;
    assign pin_out_o = latch;
    assign pin_oe_o  = dir;

    a_r3_pins_on_plain_read: assert property (@(posedge clk_i) disable iff (rst_i)
        (rd_i && !rmw_i && addr_i == 2'd0) |-> (rd_data_o == pin_i));

    a_r4_latch_on_rmw_read: assert property (@(posedge clk_i) disable iff (rst_i)
        (rd_i && rmw_i && addr_i == 2'd0) |-> (rd_data_o == pin_out_o));

    a_r6_flags_all_ones: assert property (@(posedge clk_i) disable iff (rst_i)
        (rd_i && rmw_i && addr_i == 2'd2) |-> (rd_data_o == IMPL));

    a_r5_plain_flag_read: assert property (@(posedge clk_i) disable iff (rst_i)
        (rd_i && !rmw_i && addr_i == 2'd2) |-> (rd_data_o == flags));

    a_r11_idle_bus: assert property (@(posedge clk_i) disable iff (rst_i)
        !rd_i |-> (rd_data_o == '0));

    a_r9_irq_needs_flag: assert property (@(posedge clk_i) disable iff (rst_i)
        irq_o |-> (flags != '0));

endmodule

// File: tb/rmw_port_irq_regs_tb_top.sv
`timescale 1ns/1ps
module rmw_port_irq_regs_tb_top;

    localparam int NF = 6;
    localparam int FM = (1 << NF) - 1;

    logic          clk = 1'b0;
    logic          rst_i;
    logic [1:0]    addr_i;
    logic          rd_i, wr_i, rmw_i;
    logic [7:0]    wdata_i, rd_data_o, pin_i, pin_out_o, pin_oe_o;
    logic [NF-1:0] evt_i;
    logic          irq_o;

    int checks = 0;
    int errors = 0;
    int m_latch, m_dir, m_flag, m_en;

    always #4 clk = ~clk;

    rmw_port_irq_regs #(.NFLAG(NF)) dut_i (
        .clk_i(clk), .rst_i(rst_i), .addr_i(addr_i), .rd_i(rd_i), .wr_i(wr_i),
        .rmw_i(rmw_i), .wdata_i(wdata_i), .rd_data_o(rd_data_o), .pin_i(pin_i),
        .pin_out_o(pin_out_o), .pin_oe_o(pin_oe_o), .evt_i(evt_i), .irq_o(irq_o)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // One bus cycle: drive at the falling edge, compare against the model, then advance the model.
    task automatic step(input logic [1:0] a, input logic r, input logic w, input logic m,
                        input int wd, input int pn, input int ev, input string tag);
        int exp_rd;
        string t;
        @(negedge clk);
        rst_i = 1'b0; addr_i = a; rd_i = r; wr_i = w; rmw_i = m;
        wdata_i = wd[7:0]; pin_i = pn[7:0]; evt_i = ev[NF-1:0];
        #1;
        exp_rd = 0;
        t = "R11";
        if (r) begin
            case (a)
                2'd0: begin exp_rd = m ? m_latch : (pn & 'hFF); t = m ? "R4" : "R3"; end
                2'd1: begin exp_rd = m_dir; t = "R10"; end
                2'd2: begin exp_rd = m ? FM : m_flag; t = m ? "R6" : "R5"; end
                default: begin exp_rd = m_en; t = "R10"; end
            endcase
        end
        if (tag != "") t = tag;
        check(t, int'(rd_data_o), exp_rd);
        check("R2", int'(pin_out_o), m_latch);
        check("R2", int'(pin_oe_o), m_dir);
        check("R9", int'(irq_o), int'((m_flag & m_en) != 0));
        // Model update (R7 clear-by-zero, R8 event priority, R11 rmw ignored on writes)
        if (w) begin
            case (a)
                2'd0: m_latch = wd & 'hFF;
                2'd1: m_dir = wd & 'hFF;
                2'd2: m_flag = m_flag & wd;
                default: m_en = wd & FM;
            endcase
        end
        m_flag = (m_flag | ev) & FM;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        m_latch = 0; m_dir = 0; m_flag = 0; m_en = 0;
        rst_i = 1'b1; addr_i = '0; rd_i = 0; wr_i = 0; rmw_i = 0;
        wdata_i = '0; pin_i = '0; evt_i = '0;
        repeat (3) @(posedge clk);
        // R1: reset state seen through the ports
        step(2'd0, 1, 0, 1, 0, 'h5A, 0, "R1");
        step(2'd1, 1, 0, 0, 0, 'h5A, 0, "R1");
        step(2'd2, 1, 0, 0, 0, 0, 0, "R1");
        step(2'd3, 1, 0, 0, 0, 0, 0, "R1");
        // R2 latch and direction
        step(2'd0, 0, 1, 0, 'hA5, 0, 0, "R2");
        step(2'd1, 0, 1, 0, 'h0F, 0, 0, "R2");
        // R3 pins vs R4 latch
        step(2'd0, 1, 0, 0, 0, 'h3C, 0, "R3");
        step(2'd0, 1, 0, 1, 0, 'h3C, 0, "R4");
        step(2'd0, 1, 0, 1, 0, 'hC3, 0, "R4");
        // R11 qualifier on a write has no effect
        step(2'd0, 0, 1, 1, 'h81, 'hFF, 0, "R11");
        step(2'd0, 1, 0, 1, 0, 'hFF, 0, "R11");
        // Flags: events set, plain and qualified reads
        step(2'd2, 0, 0, 0, 0, 0, 'h15, "R8");
        step(2'd2, 1, 0, 0, 0, 0, 0, "R5");
        step(2'd2, 1, 0, 1, 0, 0, 0, "R6");
        // R7 write-back of all-ones with bit0 cleared clears only bit0
        step(2'd2, 0, 1, 0, 'hFE, 0, 0, "R7");
        step(2'd2, 1, 0, 0, 0, 0, 0, "R7");
        // R8 clearing write collides with event on bit2
        step(2'd2, 0, 1, 0, 'h00, 0, 'h04, "R8");
        step(2'd2, 1, 0, 0, 0, 0, 0, "R8");
        // R9 interrupt via enable, R10 readback
        step(2'd3, 0, 1, 0, 'hFC, 0, 0, "R10");
        step(2'd3, 1, 0, 1, 0, 0, 0, "R10");
        step(2'd1, 1, 0, 1, 0, 0, 0, "R10");
        step(2'd3, 0, 0, 0, 0, 0, 0, "R9");
        step(2'd2, 0, 1, 0, 'h00, 0, 0, "R9");
        step(2'd2, 1, 0, 0, 0, 0, 0, "R9");
        // Mixed random traffic
        for (int i = 0; i < 4000; i++) begin
            int ev;
            ev = ($urandom % 4 == 0) ? int'($urandom % 64) : 0;
            step(2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                 int'($urandom % 256), int'($urandom % 256), ev, "");
        end
        finish_run();
    end

endmodule